// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This block holds three timers of an embedded processor core, all driven by a time-base tick enable. The first is a fixed-interval timer that raises a flag every power-of-two number of ticks. The second is a down-counting interval timer with an optional automatic reload. The third is a watchdog that moves through two stages and then requests a reset. The kind of reset it requests is chosen by software.

Software writes a 32-bit control word and a 32-bit status word. Status bits are cleared by writing ones to them. Software also writes the interval timer's reload value and reads the current interval count. The unit drives three level interrupt requests. It also drives a 2-bit reset request that is nonzero for one cycle when the watchdog reaches its last stage. Acting on that reset is left to other logic.

Control fields, by bit position:
- 31:30: watchdog period.
- 29:28: reset kind.
- 27: watchdog interrupt enable.
- 26: interval timer enable.
- 25:24: fixed-interval period.
- 23: fixed-interval interrupt enable.
- 22: auto-reload.

Status fields, by bit position:
- 31: watchdog first stage.
- 30: watchdog second stage.
- 29:28: last reset kind.
- 27: interval timer expired.
- 26: fixed-interval expired.

Top module: `emb_timer_unit`

## Requirements
- R1: After synchronous reset, status_o, pit_count_o, all interrupt outputs and rst_req_o are zero.
- R2: A free-running tick counter sets status bit 26 once every 2^(FIT_LOG0 + s*LOG_STEP) ticks, where s is control bits 25:24.
- R3: fit_irq_o is set together with status bit 26 only if control bit 23 is 1. It stays high until status bit 26 is cleared.
- R4: A watchdog step comes every 2^(WDT_LOG0 + s*LOG_STEP) ticks, where s is control bits 31:30. A step with status bits 31:30 at 00 or 01 sets bit 31. A step with those bits at 10 sets bit 30.
- R5: A step taken from state 10 sets wdt_irq_o if control bit 27 is 1. The output holds until status bit 30 is cleared.
- R6: A step taken from state 11 copies control bits 29:28 into status bits 29:28. In that case rst_req_o carries the same value for one cycle (0 none, 1 core, 2 chip, 3 system).
- R7: A control write stores only bits 31:22, reads as zero below them, and also counts as one watchdog step. Enables and the reset kind acting in that cycle come from the newly written value.
- R8: The interval timer runs only while control bit 26 is 1 and the reload value is above 1. It counts down once per tick. After reload ticks it sets status bit 27 and pit_irq_o. A load with a value of 0 or 1 never runs.
- R9: On expiry, with control bit 22 at 1, the count reloads and continues. With bit 22 at 0 the timer stops with a count of 0. A stopped timer holds its count.
- R10: A status write clears each of bits 31:26 written as 1 and ignores bits 25:0. A bit set by an event in the same cycle stays set. The watchdog step in that cycle sees the cleared state.
- R11: pit_irq_o drops when status bit 27 or status bit 31 is written as 1. Writing bit 31 leaves status bit 27 unchanged.
- R12: pit_count_o shows the interval count. A reload write loads the count at once. While that write is present it takes the place of counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base tick enable |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control write data |
| sts_we_i | input | 1 | Status register write strobe (write ones to clear) |
| sts_wdata_i | input | 32 | Status write data |
| pit_we_i | input | 1 | Interval reload write strobe |
| pit_wdata_i | input | 32 | Interval reload value |
| pit_count_o | output | 32 | Current interval count |
| status_o | output | 32 | Status register |
| fit_irq_o | output | 1 | Fixed-interval interrupt request |
| pit_irq_o | output | 1 | Interval timer interrupt request |
| wdt_irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 2 | Reset request kind, one-cycle pulse |

## Verification
A wrong watchdog stage shows up at status bits 31:30 and wdt_irq_o in the cycle right after the step that went wrong. A missing reset pulse shows at rst_req_o in that same cycle. An interval count that is off by one shows on pit_count_o within one cycle. It also moves the edge of status bit 27 by one tick. Errors in period selection show up later, at the next expiry of the selected period, as a bit 26 or bit 31 edge landing on the wrong tick. Running the bench with short periods keeps these delays to a few hundred cycles.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;
  localparam int REG_W = 32;

  // control field positions
  localparam int C_WPER_HI = 31;
  localparam int C_WPER_LO = 30;
  localparam int C_WKIND_HI = 29;
  localparam int C_WKIND_LO = 28;
  localparam int C_WIE = 27;
  localparam int C_PEN = 26;
  localparam int C_FPER_HI = 25;
  localparam int C_FPER_LO = 24;
  localparam int C_FIE = 23;
  localparam int C_ARE = 22;

  // status field positions
  localparam int S_WFIRST = 31;
  localparam int S_WSECOND = 30;
  localparam int S_WKIND_HI = 29;
  localparam int S_WKIND_LO = 28;
  localparam int S_PIT = 27;
  localparam int S_FIT = 26;

  localparam logic [REG_W-1:0] CTL_MASK = 32'hFFC0_0000;
  localparam logic [REG_W-1:0] STS_MASK = 32'hFC00_0000;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CORE = 2'd1,
    RK_CHIP = 2'd2,
    RK_SYS  = 2'd3
  } rst_kind_e;
endpackage

// File: rtl/emb_tick_div.sv
module emb_tick_div #(
  parameter int CNT_W    = 29,
  parameter int FIT_LOG0 = 9,
  parameter int WDT_LOG0 = 17,
  parameter int LOG_STEP = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [1:0] fit_sel_i,
  input  logic [1:0] wdt_sel_i,
  output logic       fit_evt_o,
  output logic       wdt_evt_o
);
  localparam int N_OPT = 4;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic [N_OPT-1:0] fit_opt;
  logic [N_OPT-1:0] wdt_opt;

  assign cnt_n = cnt_q + 1'b1;

  // a period ends when the selected counter bit falls on the increment
  for (genvar g = 0; g < N_OPT; g++) begin : g_opt
    localparam int FB = FIT_LOG0 + g * LOG_STEP - 1;
    localparam int WB = WDT_LOG0 + g * LOG_STEP - 1;
    assign fit_opt[g] = cnt_q[FB] & ~cnt_n[FB];
    assign wdt_opt[g] = cnt_q[WB] & ~cnt_n[WB];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_n;
  end

  assign fit_evt_o = tick_i & fit_opt[fit_sel_i];
  assign wdt_evt_o = tick_i & wdt_opt[wdt_sel_i];
endmodule

// File: rtl/emb_pit.sv
module emb_pit #(
  parameter int PIT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [PIT_W-1:0] load_val_i,
  input  logic             ctl_we_i,
  input  logic             en_i,
  input  logic             auto_i,
  input  logic             clr_flag_i,
  input  logic             clr_irq_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic [PIT_W-1:0] cnt_o
);
  logic [PIT_W-1:0] reload_q;
  logic [PIT_W-1:0] cnt_q;
  logic             run_q;
  logic             flag_q;
  logic             irq_q;
  logic             expire;
  logic             reload_ok;

  assign reload_ok = reload_q > PIT_W'(1);
  assign expire = !load_i && !ctl_we_i && run_q && tick_i && (cnt_q <= PIT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
    end else if (load_i) begin
      reload_q <= load_val_i;
      cnt_q    <= load_val_i;
      run_q    <= en_i && (load_val_i > PIT_W'(1));
    end else if (ctl_we_i) begin
      if (!en_i) begin
        run_q <= 1'b0;
      end else if (!run_q && reload_ok) begin
        run_q <= 1'b1;
        cnt_q <= reload_q;
      end
    end else if (expire) begin
      if (auto_i) begin
        cnt_q <= reload_q;
      end else begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= expire ? 1'b1 : (clr_flag_i ? 1'b0 : flag_q);
      irq_q  <= expire ? 1'b1 : (clr_irq_i ? 1'b0 : irq_q);
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
  assign cnt_o  = cnt_q;

  AST_PIT_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> flag_q); // R8
  AST_PIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load_i && !ctl_we_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/emb_wdog.sv
module emb_wdog
  import emb_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic [3:0] clr_i,
  input  logic       irq_en_i,
  input  logic [1:0] kind_i,
  output logic [1:0] state_o,
  output logic [1:0] kind_o,
  output logic       irq_o,
  output logic [1:0] rst_req_o
);
  logic [1:0] st_q, st_c, st_n;
  logic [1:0] kd_q, kd_c, kd_n;
  logic       irq_q, irq_n;
  rst_kind_e  req_q, req_n;

  assign st_c = st_q & ~clr_i[3:2];
  assign kd_c = kd_q & ~clr_i[1:0];

  always_comb begin
    st_n  = st_c;
    kd_n  = kd_c;
    irq_n = clr_i[2] ? 1'b0 : irq_q;
    req_n = RK_NONE;
    if (step_i) begin
      unique case (st_c)
        2'b10: begin
          st_n = 2'b11;
          if (irq_en_i) irq_n = 1'b1;
        end
        2'b11: begin
          kd_n  = kind_i;
          req_n = rst_kind_e'(kind_i);
        end
        default: st_n = st_c | 2'b10;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= 2'b00;
      kd_q  <= 2'b00;
      irq_q <= 1'b0;
      req_q <= RK_NONE;
    end else begin
      st_q  <= st_n;
      kd_q  <= kd_n;
      irq_q <= irq_n;
      req_q <= req_n;
    end
  end

  assign state_o   = st_q;
  assign kind_o    = kd_q;
  assign irq_o     = irq_q;
  assign rst_req_o = req_q;

  AST_WDOG_IRQ_STAGE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (st_q == 2'b11)); // R5
  AST_WDOG_REQ_STAGE: assert property (@(posedge clk) disable iff (rst)
    (req_q != RK_NONE) |-> (st_q == 2'b11)); // R6
  AST_WDOG_REQ_KIND: assert property (@(posedge clk) disable iff (rst)
    (req_q != RK_NONE) |-> (kd_q == req_q)); // R6
endmodule

// File: rtl/emb_timer_unit.sv
module emb_timer_unit
  import emb_tmr_pkg::*;
#(
  parameter int FIT_LOG0 = 9,
  parameter int WDT_LOG0 = 17,
  parameter int LOG_STEP = 4,
  parameter int PIT_W    = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        ctl_we_i,
  input  logic [31:0] ctl_wdata_i,
  input  logic        sts_we_i,
  input  logic [31:0] sts_wdata_i,
  input  logic        pit_we_i,
  input  logic [31:0] pit_wdata_i,
  output logic [31:0] pit_count_o,
  output logic [31:0] status_o,
  output logic        fit_irq_o,
  output logic        pit_irq_o,
  output logic        wdt_irq_o,
  output logic [1:0]  rst_req_o
);
  localparam int FIT_TOP = FIT_LOG0 + 3 * LOG_STEP;
  localparam int WDT_TOP = WDT_LOG0 + 3 * LOG_STEP;
  localparam int CNT_W   = (FIT_TOP > WDT_TOP) ? FIT_TOP : WDT_TOP;

  logic [REG_W-1:0] ctl_q, ctl_n, clr;
  logic             fit_evt, wdt_evt;
  logic             fit_flag_q, fit_irq_q;
  logic             pit_flag;
  logic [PIT_W-1:0] pit_cnt;
  logic [1:0]       wd_state, wd_kind;

  assign ctl_n = ctl_we_i ? (ctl_wdata_i & CTL_MASK) : ctl_q;
  assign clr   = sts_we_i ? (sts_wdata_i & STS_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_n;
  end

  emb_tick_div #(
    .CNT_W(CNT_W), .FIT_LOG0(FIT_LOG0), .WDT_LOG0(WDT_LOG0), .LOG_STEP(LOG_STEP)
  ) u_div (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .fit_sel_i(ctl_q[C_FPER_HI:C_FPER_LO]),
    .wdt_sel_i(ctl_q[C_WPER_HI:C_WPER_LO]),
    .fit_evt_o(fit_evt), .wdt_evt_o(wdt_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fit_flag_q <= 1'b0;
      fit_irq_q  <= 1'b0;
    end else begin
      fit_flag_q <= fit_evt ? 1'b1 : (clr[S_FIT] ? 1'b0 : fit_flag_q);
      fit_irq_q  <= (fit_evt && ctl_n[C_FIE]) ? 1'b1 : (clr[S_FIT] ? 1'b0 : fit_irq_q);
    end
  end

  emb_pit #(.PIT_W(PIT_W)) u_pit (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .load_i(pit_we_i), .load_val_i(pit_wdata_i[PIT_W-1:0]),
    .ctl_we_i(ctl_we_i), .en_i(ctl_n[C_PEN]), .auto_i(ctl_n[C_ARE]),
    .clr_flag_i(clr[S_PIT]), .clr_irq_i(clr[S_PIT] | clr[S_WFIRST]),
    .flag_o(pit_flag), .irq_o(pit_irq_o), .cnt_o(pit_cnt)
  );

  emb_wdog u_wdog (
    .clk(clk), .rst(rst),
    .step_i(wdt_evt | ctl_we_i),
    .clr_i(clr[S_WFIRST:S_WKIND_LO]),
    .irq_en_i(ctl_n[C_WIE]),
    .kind_i(ctl_n[C_WKIND_HI:C_WKIND_LO]),
    .state_o(wd_state), .kind_o(wd_kind),
    .irq_o(wdt_irq_o), .rst_req_o(rst_req_o)
  );

  assign status_o    = {wd_state, wd_kind, pit_flag, fit_flag_q, 26'd0};
  assign fit_irq_o   = fit_irq_q;
  assign pit_count_o = REG_W'(pit_cnt);

  AST_FIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(fit_flag_q) |-> $past(tick_i)); // R2
  AST_FIT_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    fit_irq_q |-> fit_flag_q); // R3
endmodule

// File: tb/sim_emb_timer_unit.sv
module sim_emb_timer_unit;
  localparam int FIT_LOG0 = 3;
  localparam int WDT_LOG0 = 6;
  localparam int LOG_STEP = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ctl_we = 1'b0, sts_we = 1'b0, pit_we = 1'b0;
  logic [31:0] ctl_wd = '0, sts_wd = '0, pit_wd = '0;
  logic [31:0] pit_count, status;
  logic        fit_irq, pit_irq, wdt_irq;
  logic [1:0]  rst_req;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  emb_timer_unit #(.FIT_LOG0(FIT_LOG0), .WDT_LOG0(WDT_LOG0), .LOG_STEP(LOG_STEP), .PIT_W(32)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd),
    .pit_we_i(pit_we), .pit_wdata_i(pit_wd),
    .pit_count_o(pit_count), .status_o(status),
    .fit_irq_o(fit_irq), .pit_irq_o(pit_irq), .wdt_irq_o(wdt_irq),
    .rst_req_o(rst_req)
  );

  // reference model state, built from the requirements
  longint unsigned m_tk;
  logic [31:0] m_ctl, m_sts, m_rel, m_pc;
  logic        m_prun, m_firq, m_pirq, m_wirq;
  logic [1:0]  m_req;

  function automatic bit period_end(longint unsigned tk, int k);
    longint unsigned msk = (64'd1 << k) - 1;
    return (tk & msk) == msk;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tk = 0; m_ctl = '0; m_sts = '0; m_rel = '0; m_pc = '0;
      m_prun = 0; m_firq = 0; m_pirq = 0; m_wirq = 0; m_req = 2'd0;
    end else begin
      logic [31:0] cl, cr, s;
      bit fev, wev;
      logic wn, pn;
      fev = tick && period_end(m_tk, FIT_LOG0 + int'(m_ctl[25:24]) * LOG_STEP);
      wev = tick && period_end(m_tk, WDT_LOG0 + int'(m_ctl[31:30]) * LOG_STEP);
      if (tick) m_tk = m_tk + 1;
      cl = ctl_we ? (ctl_wd & 32'hFFC0_0000) : m_ctl;
      cr = sts_we ? (sts_wd & 32'hFC00_0000) : 32'd0;
      s = m_sts & ~cr;
      if (fev) s[26] = 1'b1;
      m_firq = (fev && cl[23]) ? 1'b1 : (cr[26] ? 1'b0 : m_firq);
      wn = cr[30] ? 1'b0 : m_wirq;
      m_req = 2'd0;
      if (wev || ctl_we) begin
        case (s[31:30])
          2'b10: begin s[30] = 1'b1; if (cl[27]) wn = 1'b1; end
          2'b11: begin s[29:28] = cl[29:28]; m_req = cl[29:28]; end
          default: s[31] = 1'b1;
        endcase
      end
      pn = (cr[27] || cr[31]) ? 1'b0 : m_pirq;
      if (pit_we) begin
        m_rel = pit_wd; m_pc = pit_wd; m_prun = cl[26] && (pit_wd > 1);
      end else if (ctl_we) begin
        if (!cl[26]) m_prun = 1'b0;
        else if (!m_prun && m_rel > 1) begin m_prun = 1'b1; m_pc = m_rel; end
      end else if (m_prun && tick) begin
        if (m_pc <= 1) begin
          s[27] = 1'b1; pn = 1'b1;
          if (cl[22]) m_pc = m_rel;
          else begin m_prun = 1'b0; m_pc = '0; end
        end else m_pc = m_pc - 1;
      end
      m_ctl = cl; m_sts = s; m_wirq = wn; m_pirq = pn;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk(status[26] == m_sts[26], "R2 fixed-interval flag", {31'd0, status[26]}, {31'd0, m_sts[26]});
      chk(fit_irq == m_firq, "R3 fit irq", {31'd0, fit_irq}, {31'd0, m_firq});
      chk(status[31:30] == m_sts[31:30], "R4 watchdog stage", {30'd0, status[31:30]}, {30'd0, m_sts[31:30]});
      chk(wdt_irq == m_wirq, "R5 wdt irq", {31'd0, wdt_irq}, {31'd0, m_wirq});
      chk(status[29:28] == m_sts[29:28] && rst_req == m_req, "R6 reset kind",
          {28'd0, status[29:28], rst_req}, {28'd0, m_sts[29:28], m_req});
      chk(status[27] == m_sts[27] && pit_irq == m_pirq, "R8 interval expiry",
          {30'd0, status[27], pit_irq}, {30'd0, m_sts[27], m_pirq});
      chk(pit_count == m_pc, "R12 interval count", pit_count, m_pc);
      chk(status[25:0] == 26'd0, "R10 low status bits", status, status & 32'hFC00_0000);
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
    ctl_we = 1'b0; sts_we = 1'b0; pit_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    cmp_en = 1'b1;
    chk(status == 0 && pit_count == 0 && !fit_irq && !pit_irq && !wdt_irq && rst_req == 0,
        "R1 reset state", status | pit_count, 32'd0);

    // control writes step the watchdog (R7), reaching interrupt and reset stages
    tick = 1'b0;
    ctl_we = 1'b1; ctl_wd = 32'h2800_0000; cyc();
    chk(status == 32'h8000_0000, "R7 control write steps watchdog", status, 32'h8000_0000);
    ctl_we = 1'b1; ctl_wd = 32'h2800_0000; cyc();
    chk(status == 32'hC000_0000 && wdt_irq, "R5 second stage irq", status, 32'hC000_0000);
    ctl_we = 1'b1; ctl_wd = 32'h2800_0000; cyc();
    chk(status == 32'hF000_0000 - 32'h1000_0000 && rst_req == 2'd2, "R6 chip reset request",
        {status[31:2], rst_req}, {30'h3800_0000, 2'd2});
    cyc();
    chk(rst_req == 2'd0, "R6 request is one cycle", {30'd0, rst_req}, 32'd0);
    sts_we = 1'b1; sts_wd = 32'hFFFF_FFFF; cyc();
    chk(status == 32'd0 && !wdt_irq, "R10 write ones clears", status, 32'd0);

    // one-shot interval timer
    ctl_we = 1'b1; ctl_wd = 32'h0400_0000; cyc();
    tick = 1'b1;
    pit_we = 1'b1; pit_wd = 32'd5; cyc();
    chk(pit_count == 32'd5, "R12 load visible", pit_count, 32'd5);
    repeat (4) cyc();
    chk(pit_count == 32'd1 && !status[27], "R8 not yet expired", pit_count, 32'd1);
    cyc();
    chk(status[27] && pit_irq, "R8 expiry after reload ticks", {30'd0, status[27], pit_irq}, 32'd3);
    chk(pit_count == 32'd0, "R9 one-shot stops at zero", pit_count, 32'd0);
    repeat (2) cyc();
    chk(pit_count == 32'd0, "R9 stopped count holds", pit_count, 32'd0);
    tick = 1'b0;
    sts_we = 1'b1; sts_wd = 32'h8000_0000; cyc();
    chk(!pit_irq && status[27], "R11 bit31 drops interval irq", {30'd0, status[27], pit_irq}, 32'd2);

    // reload value of one never runs
    tick = 1'b1;
    pit_we = 1'b1; pit_wd = 32'd1; cyc();
    repeat (3) cyc();
    chk(pit_count == 32'd1, "R8 reload of one does not run", pit_count, 32'd1);

    // auto-reload
    tick = 1'b0;
    sts_we = 1'b1; sts_wd = 32'h0800_0000; cyc();
    ctl_we = 1'b1; ctl_wd = 32'h0440_0000; cyc();
    tick = 1'b1;
    pit_we = 1'b1; pit_wd = 32'd3; cyc();
    repeat (3) cyc();
    chk(pit_count == 32'd3 && status[27] && pit_irq, "R9 auto-reload restarts", pit_count, 32'd3);
    cyc();
    chk(pit_count == 32'd2, "R9 keeps counting after reload", pit_count, 32'd2);

    // constrained random phase
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 4) != 0;
      if ($urandom % 150 == 0) begin ctl_we = 1'b1; ctl_wd = $urandom; end
      if ($urandom % 60 == 0) begin sts_we = 1'b1; sts_wd = $urandom; end
      if ($urandom % 250 == 0) begin pit_we = 1'b1; pit_wd = $urandom % 48; end
      cyc();
    end

    done = 1'b1;
    cmp_en = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule